// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins a local active-low open-drain data line to a remote line that carries the same signal as dominant or recessive levels. Neither side has a fixed role on the data line. The arbiter watches both synchronized levels. Whichever side goes low (dominant) first owns the transfer. The arbiter then reproduces that level on the opposite side and ignores the echo that comes back from the side it is driving.

Ownership ends when the originating side returns to recessive. The arbiter then stops driving. It also stays passive for a programmable number of cycles, so that the remote bus can recover before a new direction is accepted. Without this wait, the bridge could read its own fading drive as fresh traffic and lock up.

The same block can serve a clock line, which never changes direction. A runtime mode input fixes the direction in that case. With master selected, levels pass from local to remote only. With slave selected, levels pass from remote to local only. Clock stretching is not carried back.

Top module: `odline_dir_arbiter`

## Requirements

Level convention: on `local_lvl` and `remote_lvl`, 0 means low or dominant. The status field `dir_state` uses these codes:
- 2'd0: idle
- 2'd1: local-to-remote
- 2'd2: remote-to-local
- 2'd3: settle

All output changes named below appear one clock after the input that causes them.

- R1: After reset, `local_pull` and `remote_dom` are 0 and `dir_state` is 2'd0.
- R2: In data mode, a low `local_lvl` seen while idle sets `remote_dom`=1, keeps `local_pull`=0 and sets `dir_state`=2'd1.
- R3: In data mode, a low `remote_lvl` seen while idle with `local_lvl` high sets `local_pull`=1 and `dir_state`=2'd2.
- R4: When both levels are low in the same idle cycle, the local side wins and the result is as in R2.
- R5: An established direction holds while its originating input stays low. The level on the driven side has no effect on the outputs.
- R6: When the originating input returns high, both outputs drop to 0 and `dir_state` shows 2'd3 for exactly SETTLE_CYCLES cycles, then returns to 2'd0.
- R7: During settle, neither side is driven, even if an input is low. A level that is still low when settle ends is arbitrated normally, starting from the first idle cycle.
- R8: With `clk_only`=1 and `is_master`=1, `remote_dom` equals the inverse of `local_lvl` one cycle later. `local_pull` stays 0. `dir_state` is 2'd1 while driving and 2'd0 otherwise.
- R9: With `clk_only`=1 and `is_master`=0, `local_pull` equals the inverse of `remote_lvl` one cycle later. `remote_dom` stays 0. `dir_state` is 2'd2 while driving and 2'd0 otherwise.
- R10: With `enable` low, both outputs go to 0 and `dir_state` goes to 2'd0 at the next edge. This applies in every state, including settle.
- R11: `local_pull` and `remote_dom` are never both 1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 0 releases both sides and returns to idle |
| clk_only | input | 1 | 1 selects fixed-direction clock behaviour |
| is_master | input | 1 | In clock mode: 1 passes local to remote, 0 passes remote to local |
| local_lvl | input | 1 | Synchronized local line level, 0 = low |
| remote_lvl | input | 1 | Synchronized remote receiver level, 0 = dominant |
| local_pull | output | 1 | 1 pulls the local line low |
| remote_dom | output | 1 | 1 requests remote dominant (feeds the timeout gate) |
| dir_state | output | 2 | Current direction status code |

## Verification

A wrong latched direction shows up at the next clock edge: the wrong one of `local_pull` and `remote_dom` rises, or an echo flips the status code. A settle counter that is off by even one cycle moves the return of `dir_state` to 2'd0 by one cycle. The same error moves by one cycle the first drive after a still-low input is re-arbitrated. The reference model is compared on every cycle, so both faults are caught at the exact edge where they occur.

// File: rtl/odarb_pkg.sv
package odarb_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE   = 2'd0,
    DIR_L2R    = 2'd1,
    DIR_R2L    = 2'd2,
    DIR_SETTLE = 2'd3
  } dir_t;
endpackage

// File: rtl/odarb_settle_timer.sv
module odarb_settle_timer #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R6
endmodule

// File: rtl/odarb_dir_fsm.sv
module odarb_dir_fsm
  import odarb_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic local_lvl,
  input  logic remote_lvl,
  output logic pull,
  output logic dom,
  output dir_t st
);
  dir_t nst;
  logic settle_done;

  odarb_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (en && (st == DIR_SETTLE)),
    .done   (settle_done)
  );

  always_comb begin
    nst = st;
    unique case (st)
      DIR_IDLE: begin
        if (!local_lvl)       nst = DIR_L2R;
        else if (!remote_lvl) nst = DIR_R2L;
      end
      DIR_L2R:    if (local_lvl)   nst = DIR_SETTLE;
      DIR_R2L:    if (remote_lvl)  nst = DIR_SETTLE;
      DIR_SETTLE: if (settle_done) nst = DIR_IDLE;
      default:    nst = DIR_IDLE;
    endcase
    if (!en) nst = DIR_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= DIR_IDLE;
      pull <= 1'b0;
      dom  <= 1'b0;
    end else begin
      st   <= nst;
      pull <= (nst == DIR_R2L);
      dom  <= (nst == DIR_L2R);
    end
  end

  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == DIR_SETTLE) |-> (!pull && !dom)); // R7
  AST_L2R_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && st == DIR_L2R && !local_lvl) |=> (st == DIR_L2R && dom)); // R5
  AST_R2L_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && st == DIR_R2L && !remote_lvl) |=> (st == DIR_R2L && pull)); // R5
  AST_RELEASE_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (en && st == DIR_L2R && local_lvl) |=> (st == DIR_SETTLE)); // R6
  AST_LOCAL_PRIO: assert property (@(posedge clk) disable iff (rst)
    (en && st == DIR_IDLE && !local_lvl) |=> (st == DIR_L2R)); // R4
endmodule

// File: rtl/odarb_fixed_path.sv
module odarb_fixed_path
  import odarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic master,
  input  logic local_lvl,
  input  logic remote_lvl,
  output logic pull,
  output logic dom,
  output dir_t st
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pull <= 1'b0;
      dom  <= 1'b0;
      st   <= DIR_IDLE;
    end else if (master) begin
      pull <= 1'b0;
      dom  <= !local_lvl;
      st   <= local_lvl ? DIR_IDLE : DIR_L2R;
    end else begin
      pull <= !remote_lvl;
      dom  <= 1'b0;
      st   <= remote_lvl ? DIR_IDLE : DIR_R2L;
    end
  end

  AST_MASTER_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    (en && master) |=> !pull); // R8
  AST_SLAVE_NO_DOM: assert property (@(posedge clk) disable iff (rst)
    (en && !master) |=> !dom); // R9
endmodule

// File: rtl/odline_dir_arbiter.sv
module odline_dir_arbiter
  import odarb_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       clk_only,
  input  logic       is_master,
  input  logic       local_lvl,
  input  logic       remote_lvl,
  output logic       local_pull,
  output logic       remote_dom,
  output logic [1:0] dir_state
);
  logic d_pull, d_dom, f_pull, f_dom;
  dir_t d_st, f_st;

  odarb_dir_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_data (
    .clk        (clk),
    .rst        (rst),
    .en         (enable && !clk_only),
    .local_lvl  (local_lvl),
    .remote_lvl (remote_lvl),
    .pull       (d_pull),
    .dom        (d_dom),
    .st         (d_st)
  );

  odarb_fixed_path u_fixed (
    .clk        (clk),
    .rst        (rst),
    .en         (enable && clk_only),
    .master     (is_master),
    .local_lvl  (local_lvl),
    .remote_lvl (remote_lvl),
    .pull       (f_pull),
    .dom        (f_dom),
    .st         (f_st)
  );

  assign local_pull = clk_only ? f_pull : d_pull;
  assign remote_dom = clk_only ? f_dom  : d_dom;
  assign dir_state  = clk_only ? f_st   : d_st;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(local_pull && remote_dom)); // R11
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!local_pull && !remote_dom && dir_state == 2'd0)); // R10
endmodule

// File: tb/odline_dir_arbiter_test.sv
module odline_dir_arbiter_test;
  localparam int NSET = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, clk_only = 1'b0, is_master = 1'b0;
  logic local_lvl = 1'b1, remote_lvl = 1'b1;
  logic local_pull, remote_dom;
  logic [1:0] dir_state;

  always #10 clk = ~clk;

  odline_dir_arbiter #(.SETTLE_CYCLES(NSET)) uut (
    .clk(clk), .rst(rst), .enable(enable), .clk_only(clk_only),
    .is_master(is_master), .local_lvl(local_lvl), .remote_lvl(remote_lvl),
    .local_pull(local_pull), .remote_dom(remote_dom), .dir_state(dir_state)
  );

  int vectors = 0, errors = 0;
  int m_state = 0, m_left = 0, m_pull = 0, m_dom = 0;
  string tag = "R1";
  bit finished = 0;

  task automatic model_edge();
    if (rst || !enable) begin
      m_state = 0; m_pull = 0; m_dom = 0; m_left = 0;
    end else if (clk_only) begin
      if (is_master) begin
        m_dom = !local_lvl; m_pull = 0; m_state = local_lvl ? 0 : 1;
      end else begin
        m_pull = !remote_lvl; m_dom = 0; m_state = remote_lvl ? 0 : 2;
      end
    end else begin
      case (m_state)
        0: if (!local_lvl) m_state = 1;
           else if (!remote_lvl) m_state = 2;
        1: if (local_lvl) begin m_state = 3; m_left = NSET; end
        2: if (remote_lvl) begin m_state = 3; m_left = NSET; end
        default: if (m_left <= 1) m_state = 0; else m_left = m_left - 1;
      endcase
      m_pull = (m_state == 2);
      m_dom  = (m_state == 1);
    end
  endtask

  task automatic compare();
    vectors++;
    if (local_pull !== 1'(m_pull) || remote_dom !== 1'(m_dom) || dir_state !== 2'(m_state)) begin
      errors++;
      $display("FAIL %s: pull/dom/state = %0b/%0b/%0d, expected %0d/%0d/%0d",
               tag, local_pull, remote_dom, dir_state, m_pull, m_dom, m_state);
    end
  endtask

  task automatic cyc(input logic l, input logic r, input int n);
    for (int i = 0; i < n; i++) begin
      local_lvl = l; remote_lvl = r;
      @(posedge clk);
      #1;
      model_edge();
      compare();
    end
  endtask

  initial begin
    tag = "R1";
    cyc(1, 1, 2);
    rst = 0; enable = 1;
    cyc(1, 1, 3);

    tag = "R2"; cyc(0, 1, 3);
    tag = "R5"; cyc(0, 0, 3);          // echo on remote ignored
    tag = "R6"; cyc(1, 0, 1); cyc(1, 1, NSET + 2);

    tag = "R3"; cyc(1, 0, 2);
    tag = "R5"; cyc(0, 0, 3);          // local echo ignored
    tag = "R6"; cyc(1, 1, NSET + 2);

    tag = "R4"; cyc(0, 0, 3);
    tag = "R7"; cyc(1, 0, NSET + 3);   // remote low during settle, then arbitrated
    cyc(1, 1, NSET + 2);
    cyc(0, 1, 2); cyc(1, 1, 2); cyc(0, 1, NSET); // local low across settle
    cyc(1, 1, NSET + 3);

    tag = "R10";
    cyc(0, 1, 2);
    enable = 0; cyc(0, 1, 2);
    enable = 1; cyc(0, 1, 2); cyc(1, 1, 2);
    enable = 0; cyc(1, 1, 1);
    enable = 1; cyc(1, 1, 2);

    enable = 0; cyc(1, 1, 1);
    clk_only = 1; is_master = 1; enable = 1;
    tag = "R8";
    cyc(1, 1, 2); cyc(0, 1, 2); cyc(1, 0, 2); cyc(0, 0, 1); cyc(1, 1, 2);

    enable = 0; cyc(1, 1, 1);
    is_master = 0; enable = 1;
    tag = "R9";
    cyc(1, 1, 2); cyc(1, 0, 2); cyc(0, 1, 2); cyc(0, 0, 1); cyc(1, 1, 2);

    tag = "R11";
    enable = 0; cyc(1, 1, 1);
    clk_only = 0; enable = 1;
    for (int k = 0; k < 40; k++) cyc(1'((k * 7) % 5 > 1), 1'((k * 3) % 4 > 0), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule